// File: doc/BRIEF.md
# Non-Restoring Single-Precision Divider

This unit divides one IEEE-754 single-precision word by another over several clock cycles. A one-cycle `start` pulse captures both operands. The significand quotient is then built one bit per cycle by a non-restoring recurrence: each step either adds or subtracts the divisor, chosen by the sign of the current partial remainder.

After 26 quotient bits have been formed, the remainder is corrected and tested for zero. The quotient is normalized by at most one position and rounded to nearest-even. The result is then presented together with a one-cycle `done` pulse.

Operands the unit does not handle raise `fail` together with `done`: a zero divisor, a denormal, infinity or NaN on either side, or a result exponent outside the normal range. A zero dividend over a valid divisor returns a signed zero at once. The surrounding logic issues one operation at a time and waits for `done`.

Top module: `fp_div_nr`

## Requirements
- R1: After reset, `done` and `fail` are low and `result` is all zeros.
- R2: The sign bit (bit 31) of every non-failing result is the XOR of the two operand sign bits.
- R3: For normal operands the biased exponent (bits 30:23) of the result is the dividend's exponent minus the divisor's exponent plus 127. It is one less when the dividend significand is below the divisor significand, and one more if rounding carries out of the significand.
- R4: The 23-bit fraction (bits 22:0) equals the exact significand quotient rounded to nearest, ties to even. Any nonzero final remainder counts as sticky information below the rounding bit.
- R5: A zero dividend (exponent and fraction fields both zero) over a normal divisor yields a zero whose sign is the XOR of the operand signs, with `fail` low.
- R6: A zero divisor raises `fail`, including when the dividend is also zero.
- R7: An operand with exponent field 255 (infinity or NaN), or with exponent field 0 and a nonzero fraction (denormal), raises `fail`.
- R8: A final biased exponent below 1 or above 254 raises `fail`. Every failing completion returns an all-zero `result`.
- R9: `done` is a single-cycle pulse. A special-case operation completes on the edge that accepts `start`. A normal division completes 26 clock edges after the accepting edge.
- R10: A `start` pulse while an operation is in progress is ignored: it produces no extra completion and does not disturb the result in flight.
- R11: `result` changes only on an edge that raises `done`, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present operands when idle |
| dividend | input | 32 | Single-precision dividend |
| divisor | input | 32 | Single-precision divisor |
| result | output | 32 | Quotient, or zero on failure |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Operation could not produce a normal result; valid with `done` |

## Verification
The normalization decision and the exponent range check resolve in the same final cycle. A quotient below one lowers the exponent in that cycle, which can push it out of range. The case is provoked by dividing the smallest normal number by a divisor whose significand is one unit above 1.0, which must fail. The same dividend over exactly 1.0 must return itself unchanged. A bench model built on plain integer division predicts both outcomes, along with many random normal pairs.

// File: rtl/fp_div_nr.sv
module fp_div_nr #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [EXP_W+FRAC_W:0]   dividend,
  input  logic [EXP_W+FRAC_W:0]   divisor,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    done,
  output logic                    fail
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int QUO_W  = MANT_W + 2;
  localparam int REM_W  = MANT_W + 3;
  localparam int XPW    = EXP_W + 2;
  localparam int CNT_W  = $clog2(QUO_W + 1);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic signed [XPW-1:0] BIAS    = XPW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [XPW-1:0] EXP_TOP = XPW'((1 << EXP_W) - 2);

  typedef enum logic [1:0] {IDLE, RUN, FIN} phase_t;

  phase_t                  phase;
  logic signed [REM_W-1:0] rem, dvs;
  logic [QUO_W-1:0]        quo;
  logic [CNT_W-1:0]        cnt;
  logic                    sgn;
  logic signed [XPW-1:0]   xp;
  logic                    busy;

  assign busy = (phase != IDLE);

  // operand fields
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign ea = dividend[WORD_W-2 -: EXP_W];
  assign eb = divisor[WORD_W-2 -: EXP_W];
  assign fa = dividend[FRAC_W-1:0];
  assign fb = divisor[FRAC_W-1:0];

  logic a_zero, b_zero, a_bad, b_bad, sgn_in;
  assign a_zero = (ea == '0) && (fa == '0);
  assign b_zero = (eb == '0) && (fb == '0);
  assign a_bad  = (ea == EXP_ONES) || ((ea == '0) && (fa != '0));
  assign b_bad  = (eb == EXP_ONES) || ((eb == '0) && (fb != '0));
  assign sgn_in = dividend[WORD_W-1] ^ divisor[WORD_W-1];

  logic signed [REM_W-1:0] ma_x, mb_x, rem_first;
  assign ma_x      = {3'b000, 1'b1, fa};
  assign mb_x      = {3'b000, 1'b1, fb};
  assign rem_first = ma_x - mb_x;

  logic signed [XPW-1:0] exp_in;
  assign exp_in = $signed({2'b00, ea}) - $signed({2'b00, eb}) + BIAS;

  // one recurrence step
  logic signed [REM_W-1:0] rem_dbl, rem_nxt;
  assign rem_dbl = rem <<< 1;
  assign rem_nxt = rem[REM_W-1] ? rem_dbl + dvs : rem_dbl - dvs;

  // remainder correction, normalization, rounding
  logic signed [REM_W-1:0] rem_fix;
  assign rem_fix = rem[REM_W-1] ? rem + dvs : rem;

  logic              norm, guard, sticky;
  logic [MANT_W-1:0] man_pre;
  logic [MANT_W:0]   man_rnd;
  assign norm    = quo[QUO_W-1];
  assign man_pre = norm ? quo[QUO_W-1:2] : quo[QUO_W-2:1];
  assign guard   = norm ? quo[1] : quo[0];
  assign sticky  = (rem_fix != '0) | (norm & quo[0]);
  assign man_rnd = {1'b0, man_pre} + {{MANT_W{1'b0}}, guard & (sticky | man_pre[0])};

  logic signed [XPW-1:0] xp_fin;
  logic                  range_bad;
  assign xp_fin    = xp - $signed({{(XPW-1){1'b0}}, ~norm})
                        + $signed({{(XPW-1){1'b0}}, man_rnd[MANT_W]});
  assign range_bad = (xp_fin < 1) || (xp_fin > EXP_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= IDLE;
      rem    <= '0;
      dvs    <= '0;
      quo    <= '0;
      cnt    <= '0;
      sgn    <= 1'b0;
      xp     <= '0;
      result <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (phase)
        IDLE: begin
          if (start) begin
            if (a_bad || b_bad || b_zero) begin
              done   <= 1'b1;
              fail   <= 1'b1;
              result <= '0;
            end else if (a_zero) begin
              done   <= 1'b1;
              result <= {sgn_in, {(WORD_W-1){1'b0}}};
            end else begin
              rem   <= rem_first;
              dvs   <= mb_x;
              quo   <= {{(QUO_W-1){1'b0}}, ~rem_first[REM_W-1]};
              cnt   <= CNT_W'(QUO_W - 1);
              sgn   <= sgn_in;
              xp    <= exp_in;
              phase <= RUN;
            end
          end
        end
        RUN: begin
          rem <= rem_nxt;
          quo <= {quo[QUO_W-2:0], ~rem_nxt[REM_W-1]};
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) phase <= FIN;
        end
        FIN: begin
          done  <= 1'b1;
          phase <= IDLE;
          if (range_bad) begin
            fail   <= 1'b1;
            result <= '0;
          end else begin
            result <= {sgn, xp_fin[EXP_W-1:0], man_rnd[FRAC_W-1:0]};
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

module fp_div_nr_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [WORD_W-1:0] dividend,
  input logic [WORD_W-1:0] divisor,
  input logic [WORD_W-1:0] result
);
  logic sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sgn_q <= 1'b0;
    else if (start && !busy) sgn_q <= dividend[WORD_W-1] ^ divisor[WORD_W-1];
  end

  a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  a_r8_fail_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (result == '0));

  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (result[WORD_W-1] == sgn_q));

  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r9_exit_completes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind fp_div_nr fp_div_nr_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .dividend(dividend), .divisor(divisor), .result(result)
);

// File: tb/fp_div_nr_bench.sv
`timescale 1ns/1ps
module fp_div_nr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] result;
  logic        done, fail;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic        flt;
    string       tag;
  } exp_t;
  exp_t sb[$];

  fp_div_nr u_fp_div_nr (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .result(result), .done(done), .fail(fail)
  );

  always #2.5 clk = ~clk;

  // spec model: {fail, result}
  function automatic logic [32:0] ref_div(input logic [31:0] x, input logic [31:0] y);
    logic [7:0]  ex, ey;
    logic [22:0] fx, fy;
    logic        s, g, st;
    longint      num, qq, rr, man;
    int          e;
    ex = x[30:23]; ey = y[30:23]; fx = x[22:0]; fy = y[22:0];
    s = x[31] ^ y[31];
    if (ex == 8'hFF || ey == 8'hFF || (ex == 0 && fx != 0) || ey == 0)
      return {1'b1, 32'h0};
    if (ex == 0) return {1'b0, s, 31'h0};
    num = longint'({1'b1, fx}) << 26;
    qq  = num / longint'({1'b1, fy});
    rr  = num % longint'({1'b1, fy});
    e   = int'(ex) - int'(ey) + 127;
    if (qq >= (longint'(1) << 26)) begin
      man = qq >> 3; g = qq[2]; st = (qq[1:0] != 0) || (rr != 0);
    end else begin
      man = qq >> 2; g = qq[1]; st = qq[0] || (rr != 0); e = e - 1;
    end
    if (g && (st || man[0])) man = man + 1;
    if (man == (longint'(1) << 24)) begin man = man >> 1; e = e + 1; end
    if (e < 1 || e > 254) return {1'b1, 32'h0};
    return {1'b0, s, 8'(e), man[22:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected done", {31'h0, fail, result}, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk((result === e.res) && (fail === e.flt), e.tag,
            {31'h0, fail, result}, {31'h0, e.flt, e.res});
      end
    end
  end

  // driver
  task automatic op(input logic [31:0] x, input logic [31:0] y, input string tag,
                    input bit interfere = 1'b0);
    logic [32:0] r;
    exp_t e;
    int n;
    int lat;
    r = ref_div(x, y);
    e.res = r[31:0]; e.flt = r[32]; e.tag = tag;
    lat = (x[30:23] == 0 || y[30:23] == 0 || x[30:23] == 8'hFF || y[30:23] == 8'hFF) ? 1 : 27;
    @(negedge clk);
    dividend = x; divisor = y; start = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      if (interfere && n == 5) begin
        dividend = 32'h40400000; divisor = 32'h3F800000; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == lat, "R9 latency", 64'(n), 64'(lat));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0 && result === 32'h0, "R1 reset state",
        {30'h0, done, fail, result}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0 && result === 32'h0, "R1 after release",
        {30'h0, done, fail, result}, 64'h0);

    chk(ref_div(32'h3F800000, 32'h40400000) == {1'b0, 32'h3EAAAAAB}, "R4 model one third",
        64'(ref_div(32'h3F800000, 32'h40400000)), 64'h3EAAAAAB);

    op(32'h3F800000, 32'h3F800000, "R3 one over one");
    op(32'h40C00000, 32'h40400000, "R3 six over three");
    op(32'h3F800000, 32'h40400000, "R4 one third sticky");
    op(32'hC0000000, 32'h40400000, "R2 negative dividend");
    op(32'hC0E00000, 32'hC0400000, "R2 both negative");
    op(32'h3F800000, 32'h3F800001, "R3 normalize shift");
    op(32'h80000000, 32'h40400000, "R5 negative zero dividend");
    op(32'h00000000, 32'hC0400000, "R5 zero over negative");
    op(32'h3F800000, 32'h00000000, "R6 zero divisor");
    op(32'h00000000, 32'h80000000, "R6 zero over zero");
    op(32'h7F800000, 32'h3F800000, "R7 infinite dividend");
    op(32'h3F800000, 32'h7FC00000, "R7 NaN divisor");
    op(32'h00000123, 32'h3F800000, "R7 denormal dividend");
    op(32'h00000000, 32'h00400000, "R7 denormal divisor");
    op(32'h7F7FFFFF, 32'h3F000000, "R8 overflow");
    op(32'h00800000, 32'h3F800001, "R8 underflow by normalization");
    op(32'h00800000, 32'h3F800000, "R8 smallest normal kept");
    op(32'h7F000000, 32'h3F800000, "R8 largest exponent kept");

    op(32'h40A00000, 32'h40400000, "R10 start while running", 1'b1);
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R10 no extra completion", 64'(sb.size()), 64'h0);
    chk(done === 1'b0, "R11 idle no done", {63'h0, done}, 64'h0);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      x[30:23] = 8'(60 + ($urandom % 136));
      y[30:23] = 8'(60 + ($urandom % 136));
      op(x, y, "R4 random quotient");
    end
    for (int i = 0; i < 10; i++) begin
      op($urandom, $urandom, "R3 random full range");
    end

    repeat (5) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule